// File: doc/BRIEF.md
# Command/Response FIFO Status Engine

This block is the byte-wide command and response path of a trusted-module register interface, serving the locality that currently owns the interface. Software pushes command bytes one at a time into a data FIFO register. The engine reads the total command length from the header while the bytes stream in. A status register shows whether more bytes are owed, whether a response is waiting and whether the engine is ready for a new command. A 16-bit burst count tells software how many bytes it can move before it has to poll again.

Writing the go bit after a complete command starts execution. The executor is a stub: after a fixed number of cycles it makes available a response of fixed length with a well-formed header. Software reads the response back through the same FIFO register. Writing the command-ready bit aborts any step in progress and returns the engine to the ready state.

Top module: `cmdrsp_fifo_engine`

## Requirements
- R1: After reset the status byte at offset 0x18 reads 0xC8, which means valid (bit 7), command-ready (bit 6) and data-expected (bit 3) are set. The burst count reads DEPTH (64): the low byte is at 0x19 and the high byte is at 0x1A.
- R2: Data-expected (status bit 3) stays at 1 until the write that completes the length declared in header bytes 2..5, read as a big-endian value. After that write it reads 0. Command-ready (bit 6) reads 0 from the first command byte onward.
- R3: While a command is being received, or once a command is complete, the burst count equals DEPTH minus the number of command bytes accepted so far.
- R4: If the declared length is above DEPTH or below 10, the engine returns to the ready state at the sixth byte (status 0xC8, burst count DEPTH).
- R5: A FIFO write that arrives when no command byte is owed is discarded and sets the sticky overflow flag (status bit 2). Only a command-ready write clears that flag.
- R6: Writing go (status bit 5) after a complete command starts execution. For EXEC_CYCLES cycles, data-available and data-expected read 0 and the burst count reads 0.
- R7: A go write has no effect unless a complete command is held.
- R8: When execution ends, data-available (bit 4) rises. FIFO reads then return the response bytes in order: 0x80, 0xC4, the 32-bit big-endian length RESP_LEN, then byte i = (7*i + 0x11) mod 256. The burst count equals the number of bytes still unread. Data-available clears after the last byte has been read.
- R9: A command-ready write (status bit 6) returns the engine to the ready state from any state. It takes priority over a go bit set in the same write and over an execution that completes in the same cycle.
- R10: Valid (status bit 7) reads 0 for the one cycle after each FIFO read or write.
- R11: A FIFO read outside response delivery returns 0xFF and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset inside the locality window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, same cycle |

## Verification
The two functions that can fall in the same cycle are a command-ready abort and the internal end of execution. The bench provokes this by writing command-ready exactly on the last cycle of the execution window, counted from the go write, and it also writes a byte that carries both command-ready and go. The behavioural model applies the abort ahead of the timer tick and the go. After either collision the status must read 0xC8 and the burst count must read 64, and no response may appear.

// File: rtl/cre_pkg.sv
package cre_pkg;

  typedef enum logic [2:0] {
    ST_READY,
    ST_RECV,
    ST_FULL,
    ST_EXEC,
    ST_RESP,
    ST_DONE
  } eng_state_e;

  localparam int HDR_BYTES    = 10;
  localparam int LEN_LAST_IDX = 5;

  localparam int B_VALID  = 7;
  localparam int B_CREADY = 6;
  localparam int B_GO     = 5;
  localparam int B_AVAIL  = 4;
  localparam int B_EXPECT = 3;
  localparam int B_OVF    = 2;

  // Response byte generator for the executor stub.
  function automatic logic [7:0] rsp_byte(input logic [15:0] idx,
                                          input logic [15:0] total);
    logic [7:0] v;
    case (idx)
      16'd0:   v = 8'h80;
      16'd1:   v = 8'hC4;
      16'd2:   v = 8'h00;
      16'd3:   v = 8'h00;
      16'd4:   v = total[15:8];
      16'd5:   v = total[7:0];
      default: v = 8'(idx[7:0] * 8'd7 + 8'h11);
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cre_cmd_rx.sv
module cre_cmd_rx
  import cre_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  output logic             hdr_bad_o,
  output logic             last_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LEN_LO = CNT_W'(2);
  localparam logic [CNT_W-1:0] LEN_HI = CNT_W'(LEN_LAST_IDX);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [31:0]      len_q, len_d, len_full;
  logic             en;

  assign len_full = {len_q[23:0], wdata_i};

  always_comb begin
    cnt_d = cnt_q;
    len_d = len_q;
    en    = clr_i | wr_i;
    if (clr_i) begin
      cnt_d = '0;
      len_d = '0;
    end else if (wr_i) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q >= LEN_LO && cnt_q <= LEN_HI) len_d = len_full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  assign hdr_bad_o = wr_i && (cnt_q == LEN_HI) &&
                     (len_full > 32'(DEPTH) || len_full < 32'(HDR_BYTES));
  assign last_o    = wr_i && (cnt_q > LEN_HI) && (len_q == 32'(cnt_q) + 32'd1);
  assign cnt_o     = cnt_q;

  // R4: a bad declared length must clear the receive counters
  p_hdr_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_bad_o |-> clr_i);
  // R2: the count of accepted bytes never passes the buffer depth
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/cre_rsp_tx.sv
module cre_rsp_tx
  import cre_pkg::*;
#(
  parameter int RESP_LEN    = 14,
  parameter int EXEC_CYCLES = 20,
  parameter int IDX_W       = $clog2(RESP_LEN + 1),
  parameter int TMR_W       = $clog2(EXEC_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             exec_i,
  input  logic             pop_i,
  output logic             done_o,
  output logic             last_o,
  output logic [7:0]       byte_o,
  output logic [IDX_W-1:0] left_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RESP_LEN - 1);

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             en;

  always_comb begin
    tmr_d = tmr_q;
    idx_d = idx_q;
    en    = clr_i | start_i | exec_i | pop_i;
    if (clr_i) begin
      tmr_d = '0;
      idx_d = '0;
    end else if (start_i) begin
      tmr_d = TMR_W'(EXEC_CYCLES);
      idx_d = '0;
    end else begin
      if (exec_i && tmr_q != '0) tmr_d = tmr_q - 1'b1;
      if (pop_i) idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      idx_q <= '0;
    end else if (en) begin
      tmr_q <= tmr_d;
      idx_q <= idx_d;
    end
  end

  assign done_o = exec_i && (tmr_q == TMR_W'(1));
  assign last_o = pop_i && (idx_q == LAST_IDX);
  assign byte_o = rsp_byte(16'(idx_q), 16'(RESP_LEN));
  assign left_o = IDX_W'(RESP_LEN) - idx_q;

  // R8: the read index never runs past the response length
  p_idx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(RESP_LEN));
  // R6: a go loads the full execution window
  p_start_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !clr_i) |=> tmr_q == TMR_W'(EXEC_CYCLES));

endmodule

// File: rtl/cmdrsp_fifo_engine.sv
module cmdrsp_fifo_engine
  import cre_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter int                DEPTH       = 64,
  parameter int                RESP_LEN    = 14,
  parameter int                EXEC_CYCLES = 20,
  parameter logic [ADDR_W-1:0] STS_OFS     = 12'h018,
  parameter logic [ADDR_W-1:0] FIFO_OFS    = 12'h024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(RESP_LEN + 1);
  localparam int TMR_W = $clog2(EXEC_CYCLES + 1);
  localparam logic [ADDR_W-1:0] BURST_LO = STS_OFS + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] BURST_HI = STS_OFS + ADDR_W'(2);

  eng_state_e       state_q, state_d;
  logic             ovf_q, ovf_d, acc_q, acc_d;
  logic             sts_sel, fifo_sel, fifo_wr, fifo_rd;
  logic             ready_wr, go_wr, accept_wr, pop, start;
  logic             hdr_bad, last_wr, done, last_rd, clr_rx;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] left;
  logic [7:0]       rsp_data, sts;
  logic [15:0]      burst;
  logic             receiving;

  assign sts_sel   = (bus_addr == STS_OFS);
  assign fifo_sel  = (bus_addr == FIFO_OFS);
  assign fifo_wr   = bus_wr && fifo_sel;
  assign fifo_rd   = bus_rd && fifo_sel;
  assign ready_wr  = bus_wr && sts_sel && bus_wdata[B_CREADY];
  assign go_wr     = bus_wr && sts_sel && bus_wdata[B_GO] && !bus_wdata[B_CREADY];
  assign receiving = (state_q == ST_READY) || (state_q == ST_RECV);
  assign accept_wr = fifo_wr && receiving;
  assign pop       = fifo_rd && (state_q == ST_RESP);
  assign start     = go_wr && (state_q == ST_FULL);
  assign clr_rx    = ready_wr || hdr_bad;

  cre_cmd_rx #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_rx),
    .wr_i      (accept_wr),
    .wdata_i   (bus_wdata),
    .hdr_bad_o (hdr_bad),
    .last_o    (last_wr),
    .cnt_o     (cnt)
  );

  cre_rsp_tx #(.RESP_LEN(RESP_LEN), .EXEC_CYCLES(EXEC_CYCLES),
               .IDX_W(IDX_W), .TMR_W(TMR_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (ready_wr),
    .start_i (start),
    .exec_i  (state_q == ST_EXEC),
    .pop_i   (pop),
    .done_o  (done),
    .last_o  (last_rd),
    .byte_o  (rsp_data),
    .left_o  (left)
  );

  // next state
  always_comb begin
    state_d = state_q;
    ovf_d   = ovf_q;
    acc_d   = fifo_wr || fifo_rd;
    if (ready_wr) begin
      state_d = ST_READY;
      ovf_d   = 1'b0;
    end else begin
      if (fifo_wr && !accept_wr) ovf_d = 1'b1;
      case (state_q)
        ST_READY, ST_RECV: begin
          if (accept_wr) begin
            if (hdr_bad)      state_d = ST_READY;
            else if (last_wr) state_d = ST_FULL;
            else              state_d = ST_RECV;
          end
        end
        ST_FULL: if (start)   state_d = ST_EXEC;
        ST_EXEC: if (done)    state_d = ST_RESP;
        ST_RESP: if (last_rd) state_d = ST_DONE;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READY;
      ovf_q   <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ovf_q   <= ovf_d;
      acc_q   <= acc_d;
    end
  end

  always_comb begin
    sts           = '0;
    sts[B_VALID]  = !acc_q;
    sts[B_CREADY] = (state_q == ST_READY);
    sts[B_AVAIL]  = (state_q == ST_RESP);
    sts[B_EXPECT] = receiving;
    sts[B_OVF]    = ovf_q;
  end

  always_comb begin
    case (state_q)
      ST_READY, ST_RECV, ST_FULL: burst = 16'(DEPTH) - 16'(cnt);
      ST_RESP:                    burst = 16'(left);
      default:                    burst = '0;
    endcase
  end

  always_comb begin
    if (bus_addr == STS_OFS)       bus_rdata = sts;
    else if (bus_addr == BURST_LO) bus_rdata = burst[7:0];
    else if (bus_addr == BURST_HI) bus_rdata = burst[15:8];
    else if (fifo_sel)             bus_rdata = (state_q == ST_RESP) ? rsp_data : 8'hFF;
    else                           bus_rdata = 8'h00;
  end

  // R9: command-ready wins over everything else in its cycle
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready_wr |=> state_q == ST_READY);
  // R6: go on a complete command enters execution
  p_go_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> state_q == ST_EXEC);
  // R7: go outside a complete command leaves the state alone
  p_go_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && (receiving || state_q == ST_RESP || state_q == ST_DONE)) |=> $stable(state_q));
  // R10: valid drops for one cycle after a FIFO access
  p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr || fifo_rd) |=> !sts[B_VALID]);
  // R5: overflow flag holds until command-ready
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ready_wr) |=> ovf_q);
  // R8: the last response byte read ends delivery
  p_deliver_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_rd && !ready_wr) |=> state_q == ST_DONE);

endmodule

// File: tb/cmdrsp_fifo_engine_tb_top.sv
module cmdrsp_fifo_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int RESP_LEN   = 14;
  localparam int EXEC_CYC   = 20;
  localparam logic [11:0] A_STS  = 12'h018;
  localparam logic [11:0] A_BLO  = 12'h019;
  localparam logic [11:0] A_BHI  = 12'h01A;
  localparam logic [11:0] A_FIFO = 12'h024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R1";
  logic [7:0] last_act;

  // behavioural reference model
  logic [7:0] cmd_q[$];
  logic [7:0] rsp_q[$];
  int   mst;
  int   mtmr;
  int   mlen;
  bit   movf, macc;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdrsp_fifo_engine #(.ADDR_W(12), .DEPTH(DEPTH), .RESP_LEN(RESP_LEN),
                       .EXEC_CYCLES(EXEC_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] exp_rsp(int i);
    if (i == 0) return 8'h80;
    if (i == 1) return 8'hC4;
    if (i == 2 || i == 3) return 8'h00;
    if (i == 4) return 8'((RESP_LEN >> 8) & 255);
    if (i == 5) return 8'(RESP_LEN & 255);
    return 8'((7 * i + 17) % 256);
  endfunction

  function automatic logic [7:0] model_rd(logic [11:0] a);
    int b;
    b = (mst <= 2) ? DEPTH - cmd_q.size() : (mst == 4) ? rsp_q.size() : 0;
    if (a == A_STS)  return {!macc, mst == 0, 1'b0, mst == 4, mst <= 1, movf, 2'b00};
    if (a == A_BLO)  return 8'(b & 255);
    if (a == A_BHI)  return 8'((b >> 8) & 255);
    if (a == A_FIFO) return (mst == 4) ? rsp_q[0] : 8'hFF;
    return 8'h00;
  endfunction

  task automatic model_step(bit w, bit r, logic [11:0] a, logic [7:0] d);
    int ost = mst;
    bit acc_n = (w || r) && (a == A_FIFO);
    if (w && a == A_STS && d[6]) begin
      mst = 0; movf = 0; cmd_q.delete(); rsp_q.delete();
    end else begin
      if (ost == 3) begin
        if (mtmr == 1) begin
          for (int i = 0; i < RESP_LEN; i++) rsp_q.push_back(exp_rsp(i));
          mst = 4;
        end else mtmr--;
      end
      if (w && a == A_STS && d[5] && ost == 2) begin
        mst = 3; mtmr = EXEC_CYC;
      end
      if (w && a == A_FIFO) begin
        if (ost <= 1) begin
          cmd_q.push_back(d);
          mst = 1;
          if (cmd_q.size() == 6) begin
            mlen = {cmd_q[2], cmd_q[3], cmd_q[4], cmd_q[5]};
            if (mlen > DEPTH || mlen < 10) begin
              mst = 0; cmd_q.delete();
            end
          end else if (cmd_q.size() > 6 && cmd_q.size() == mlen) mst = 2;
        end else movf = 1;
      end
      if (r && a == A_FIFO && ost == 4) begin
        void'(rsp_q.pop_front());
        if (rsp_q.size() == 0) mst = 5;
      end
    end
    macc = acc_n;
  endtask

  // one bus cycle, compared against the model
  task automatic step(bit w, bit r, logic [11:0] a, logic [7:0] d);
    logic [7:0] e;
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    #2;
    e = model_rd(a);
    last_act = bus_rdata;
    n_checks++;
    if (bus_rdata !== e) begin
      n_fails++;
      $display("FAIL %s: addr %h rdata %h expected %h", cur_req, a, bus_rdata, e);
    end
    @(posedge clk);
    model_step(w, r, a, d);
    #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(string req, logic [11:0] a, logic [7:0] exp);
    cur_req = req;
    step(0, 1, a, 8'h00);
    chk(req, last_act, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, A_STS, 8'h00);
  endtask

  task automatic wr_fifo(logic [7:0] d);
    step(1, 0, A_FIFO, d);
  endtask

  task automatic wr_sts(logic [7:0] d);
    step(1, 0, A_STS, d);
  endtask

  // header with the given declared length, then n bytes in total
  task automatic send(int len, int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      case (i)
        0: b = 8'h00;
        1: b = 8'hC1;
        2: b = 8'((len >> 24) & 255);
        3: b = 8'((len >> 16) & 255);
        4: b = 8'((len >> 8) & 255);
        5: b = 8'(len & 255);
        default: b = 8'(i * 3);
      endcase
      wr_fifo(b);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = A_STS; bus_wdata = 0;
    mst = 0; mtmr = 0; mlen = 0; movf = 0; macc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek("R1", A_STS, 8'hC8);
    peek("R1", A_BLO, 8'h40);
    peek("R1", A_BHI, 8'h00);

    // R2 / R3 reception of a 12-byte command
    cur_req = "R2";
    send(12, 6);
    idle(1);
    peek("R2", A_STS, 8'h88);
    peek("R3", A_BLO, 8'h3A);
    cur_req = "R2";
    send(12, 12 - 6);
    idle(1);
    peek("R2", A_STS, 8'h80);
    peek("R3", A_BLO, 8'h34);

    // R10 valid drop, R5 overflow
    cur_req = "R5";
    wr_fifo(8'hEE);
    peek("R10", A_STS, 8'h04);
    peek("R5", A_STS, 8'h84);
    peek("R5", A_BLO, 8'h34);

    // R6 execution window
    cur_req = "R6";
    wr_sts(8'h20);
    peek("R6", A_STS, 8'h84);
    peek("R6", A_BLO, 8'h00);
    cur_req = "R6";
    idle(EXEC_CYC - 2);
    peek("R8", A_STS, 8'h94);
    peek("R8", A_BLO, 8'(RESP_LEN));

    // R8 response readback
    for (int i = 0; i < RESP_LEN; i++) begin
      cur_req = "R8";
      step(0, 1, A_FIFO, 8'h00);
      chk("R8", last_act, exp_rsp(i));
    end
    idle(1);
    peek("R8", A_STS, 8'h84);
    peek("R11", A_FIFO, 8'hFF);
    idle(1);
    peek("R11", A_STS, 8'h84);

    // R5 clear, R7 go ignored
    cur_req = "R9";
    wr_sts(8'h40);
    idle(1);
    peek("R5", A_STS, 8'hC8);
    cur_req = "R7";
    wr_sts(8'h20);
    peek("R7", A_STS, 8'hC8);
    send(20, 4);
    wr_sts(8'h20);
    idle(1);
    peek("R7", A_STS, 8'h88);
    wr_sts(8'h40);

    // R4 bad lengths
    cur_req = "R4";
    send(100, 6);
    idle(1);
    peek("R4", A_STS, 8'hC8);
    peek("R4", A_BLO, 8'h40);
    cur_req = "R4";
    send(5, 6);
    idle(1);
    peek("R4", A_STS, 8'hC8);
    send(64, 6);
    idle(1);
    peek("R4", A_STS, 8'h88);
    wr_sts(8'h40);

    // R9 command-ready and go in one write
    cur_req = "R9";
    send(10, 10);
    wr_sts(8'h60);
    idle(1);
    peek("R9", A_STS, 8'hC8);

    // R9 abort on the cycle execution completes
    cur_req = "R9";
    send(10, 10);
    wr_sts(8'h20);
    idle(EXEC_CYC - 1);
    wr_sts(8'h40);
    idle(1);
    peek("R9", A_STS, 8'hC8);
    peek("R9", A_BLO, 8'h40);

    // R11 FIFO read during reception
    cur_req = "R11";
    send(16, 3);
    peek("R11", A_FIFO, 8'hFF);
    idle(1);
    peek("R11", A_BLO, 8'h3D);
    wr_sts(8'h40);

    // R9 abort during delivery
    cur_req = "R9";
    send(10, 10);
    wr_sts(8'h20);
    idle(EXEC_CYC);
    for (int i = 0; i < 3; i++) step(0, 1, A_FIFO, 8'h00);
    wr_sts(8'h40);
    idle(1);
    peek("R9", A_STS, 8'hC8);
    peek("R9", A_BLO, 8'h40);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule